// File: doc/BRIEF.md
# Multiplier-Free Constant-Coefficient FIR Filter

This block is a fully parallel finite impulse response filter whose coefficients are fixed when the design is elaborated. It contains no multipliers. A shift register keeps the most recent accepted signed samples. For each bit position, the bits of that position taken across all taps form an address. That address selects a precomputed sum of the coefficients whose tap bit is set. The partial sums for the bit positions are then weighted by powers of two and added, which gives one filtered result per clock.

The tables are computed at elaboration from the coefficient parameter, so no external file is needed. They can be split into groups of a few taps each, which keeps each table small, and the group outputs are added. A new sample can be offered on every clock through a valid strobe. Each accepted sample produces exactly one result after a fixed three-cycle latency. The result is full precision, so it never overflows.

Top module: `dafir_top`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, `out_vld` is 0, `out_y` is 0 and every stored tap is 0. Samples that were in flight when reset was asserted produce no result. After reset, results depend only on samples accepted after the reset.
- R2: For each accepted sample, `out_y` equals the exact sum over k of COEF[k] × x[n−k]. Here x[n] is the newest accepted sample (tap 0) and x[n−k] is the sample accepted k samples earlier. The result is signed and OUT_W = COEF_W + SMP_W + ceil(log2(NTAPS)) bits wide, with no truncation.
- R3: `out_vld` is high in a given cycle exactly when `in_vld` was high three rising edges earlier. Back-to-back strobes give back-to-back results.
- R4: A sample is taken only when `in_vld` is high. While `in_vld` is low, the value on `in_smp` has no effect on the taps or on any later result.
- R5: While `out_vld` is low, `out_y` keeps the value of the most recent result (0 after reset).
- R6: Bit SMP_W−1 of a sample carries weight −2^(SMP_W−1) (two's complement). An input of −32768 followed by zeros yields −32768 × COEF[k] exactly.
- R7: A single sample of value 1 followed by zeros yields the coefficients in tap order: COEF[0], COEF[1], … COEF[NTAPS−1], then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe; `in_smp` is taken when high |
| in_smp | input | SMP_W | Signed two's-complement input sample |
| out_vld | output | 1 | High for one cycle per filtered result |
| out_y | output | OUT_W | Signed full-precision filter result |

## Verification
Two things routinely coincide in the same cycle. In one, a new sample shifts into the taps on the same edge that the pipeline retires a result computed from the previous contents of the taps. The other is an idle gap with garbage on `in_smp` while earlier results are still emerging. Full-rate streams and streams with gaps of varying length, some filled with pseudo-random garbage, provoke both. Each emitted value is judged against a multiply-accumulate model kept in the bench. Every cycle is also checked against the expected strobe timing and for a held output. A reset asserted mid-stream confirms that in-flight results are dropped and the taps start again from zero.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    // Smallest r such that 2**r >= v (v >= 1).
    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if ((1 << i) < v) r = i + 1;
        end
        return r;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline #(
    parameter int NTAPS = 7,
    parameter int SMP_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            shift_en,
    input  logic [SMP_W-1:0]                smp_in,
    output logic [NTAPS-1:0][SMP_W-1:0]     taps
);

    typedef struct packed {
        logic [NTAPS-1:0][SMP_W-1:0] taps;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_en) begin
            line_d.taps[0] = smp_in;
            for (int k = 1; k < NTAPS; k++) begin
                line_d.taps[k] = line_q.taps[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign taps = line_q.taps;

endmodule

// File: rtl/dafir_da_lut.sv
module dafir_da_lut #(
    parameter int NTAPS    = 7,
    parameter int SMP_W    = 16,
    parameter int SUM_W    = 19,
    parameter int GRP_TAPS = 4,
    parameter int COEF [NTAPS] = '{1495, -943, -9687, 18270, -9687, -943, 1495}
) (
    input  logic [NTAPS-1:0][SMP_W-1:0]  taps,
    output logic [SMP_W-1:0][SUM_W-1:0]  pp
);

    localparam int NGRP  = dafir_pkg::ceil_div(NTAPS, GRP_TAPS);
    localparam int PAD_N = NGRP * GRP_TAPS;
    localparam int TBL_N = 1 << GRP_TAPS;

    // Sum of the coefficients of group grp selected by the set bits of addr.
    function automatic logic [SUM_W-1:0] subset_sum(input int grp, input int addr);
        longint acc;
        int     idx;
        acc = 0;
        for (int i = 0; i < GRP_TAPS; i++) begin
            idx = grp * GRP_TAPS + i;
            if (((addr >> i) & 1) == 1) begin
                if (idx < NTAPS) acc = acc + longint'(COEF[idx]);
            end
        end
        return acc[SUM_W-1:0];
    endfunction

    logic [PAD_N-1:0][SMP_W-1:0] taps_pad;
    logic [SUM_W-1:0]            part [SMP_W][NGRP];

    always_comb begin
        taps_pad = '0;
        taps_pad[NTAPS-1:0] = taps;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [SUM_W-1:0] tbl [TBL_N];
        for (genvar e = 0; e < TBL_N; e++) begin : g_ent
            assign tbl[e] = subset_sum(g, e);
        end
        for (genvar b = 0; b < SMP_W; b++) begin : g_bit
            logic [GRP_TAPS-1:0] addr;
            always_comb begin
                for (int i = 0; i < GRP_TAPS; i++) begin
                    addr[i] = taps_pad[g*GRP_TAPS + i][b];
                end
            end
            assign part[b][g] = tbl[addr];
        end
    end

    always_comb begin
        for (int b = 0; b < SMP_W; b++) begin
            pp[b] = '0;
            for (int g = 0; g < NGRP; g++) begin
                pp[b] = pp[b] + part[b][g];
            end
        end
    end

endmodule

// File: rtl/dafir_shift_add.sv
module dafir_shift_add #(
    parameter int SMP_W = 16,
    parameter int SUM_W = 19,
    parameter int OUT_W = 35
) (
    input  logic [SMP_W-1:0][SUM_W-1:0]  pp,
    output logic signed [OUT_W-1:0]      y
);

    logic signed [OUT_W-1:0] term [SMP_W];

    for (genvar b = 0; b < SMP_W; b++) begin : g_term
        logic signed [OUT_W-1:0] ext;
        assign ext     = OUT_W'($signed(pp[b]));
        assign term[b] = ext <<< b;
    end

    // Sign-bit slice carries negative weight.
    always_comb begin
        y = '0;
        for (int b = 0; b < SMP_W; b++) begin
            if (b == SMP_W - 1) y = y - term[b];
            else                y = y + term[b];
        end
    end

endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
    parameter int NTAPS    = 7,
    parameter int SMP_W    = 16,
    parameter int COEF_W   = 16,
    parameter int GRP_TAPS = 4,
    parameter int COEF [NTAPS] = '{1495, -943, -9687, 18270, -9687, -943, 1495},
    localparam int SUM_W   = COEF_W + dafir_pkg::ceil_log2(NTAPS),
    localparam int OUT_W   = SUM_W + SMP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [SMP_W-1:0]  in_smp,
    output logic                     out_vld,
    output logic signed [OUT_W-1:0]  out_y
);

    typedef struct packed {
        logic                         tap_vld;
        logic                         pp_vld;
        logic [SMP_W-1:0][SUM_W-1:0]  pp;
        logic                         y_vld;
        logic [OUT_W-1:0]             y;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NTAPS-1:0][SMP_W-1:0] taps_w;
    logic [SMP_W-1:0][SUM_W-1:0] lut_pp;
    logic signed [OUT_W-1:0]     sum_y;

    dafir_tapline #(.NTAPS(NTAPS), .SMP_W(SMP_W)) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_vld),
        .smp_in   (in_smp),
        .taps     (taps_w)
    );

    dafir_da_lut #(
        .NTAPS(NTAPS), .SMP_W(SMP_W), .SUM_W(SUM_W),
        .GRP_TAPS(GRP_TAPS), .COEF(COEF)
    ) u_lut (
        .taps (taps_w),
        .pp   (lut_pp)
    );

    dafir_shift_add #(.SMP_W(SMP_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_sum (
        .pp (pipe_q.pp),
        .y  (sum_y)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.tap_vld = in_vld;
        pipe_d.pp_vld  = pipe_q.tap_vld;
        pipe_d.y_vld   = pipe_q.pp_vld;
        if (pipe_q.tap_vld) pipe_d.pp = lut_pp;
        if (pipe_q.pp_vld)  pipe_d.y  = sum_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld = pipe_q.y_vld;
    assign out_y   = pipe_q.y;

endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
    parameter int NTAPS = 7,
    parameter int SMP_W = 16,
    parameter int OUT_W = 35
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_vld,
    input logic [SMP_W-1:0]             in_smp,
    input logic                         out_vld,
    input logic [OUT_W-1:0]             out_y,
    input logic [NTAPS-1:0][SMP_W-1:0]  taps
);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##2 out_vld);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ##2 !out_vld);

    // R5
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_y));

    // R4
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(taps));

    // R4
    tap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (taps[0] == $past(in_smp)));

    // R2
    tap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (taps[NTAPS-1] == $past(taps[NTAPS-2])));

endmodule

bind dafir_top dafir_chk #(.NTAPS(NTAPS), .SMP_W(SMP_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_smp  (in_smp),
    .out_vld (out_vld),
    .out_y   (out_y),
    .taps    (taps_w)
);

// File: tb/tb_dafir_top.sv
module tb_dafir_top;

    localparam int CLK_PERIOD = 10;
    localparam int NTAPS    = 7;
    localparam int SMP_W    = 16;
    localparam int COEF_W   = 16;
    localparam int GRP_TAPS = 4;
    localparam int COEF [NTAPS] = '{1495, -943, -9687, 18270, -9687, -943, 1495};
    localparam int OUT_W    = COEF_W + SMP_W + dafir_pkg::ceil_log2(NTAPS);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_vld = 1'b0;
    logic signed [SMP_W-1:0] in_smp = '0;
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_y;

    int     n_chk  = 0;
    int     n_fail = 0;
    bit     done   = 1'b0;
    string  cur_tag = "R2";
    longint hist [NTAPS];
    longint exp_q [$];
    string  tag_q [$];
    logic [2:0] vld_hist = '0;
    longint last_y = 0;
    logic [15:0] lf = 16'hACE1;

    dafir_top #(
        .NTAPS(NTAPS), .SMP_W(SMP_W), .COEF_W(COEF_W),
        .GRP_TAPS(GRP_TAPS), .COEF(COEF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp),
        .out_vld(out_vld), .out_y(out_y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: direct multiply-accumulate over accepted samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) hist[k] = 0;
            exp_q.delete();
            tag_q.delete();
            vld_hist <= '0;
        end else begin
            vld_hist <= {vld_hist[1:0], in_vld};
            if (in_vld) begin
                longint acc;
                for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = longint'(in_smp);
                acc = 0;
                for (int k = 0; k < NTAPS; k++) acc += hist[k] * longint'(COEF[k]);
                exp_q.push_back(acc);
                tag_q.push_back(cur_tag);
            end
        end
    end

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_y = 0;
        end else if (!done) begin
            check(out_vld == vld_hist[2], "R3", longint'(out_vld), longint'(vld_hist[2]));
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", 1, 0);
                end else begin
                    longint e;
                    string  t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(longint'(out_y) == e, t, longint'(out_y), e);
                end
                last_y = longint'(out_y);
            end else begin
                check(longint'(out_y) == last_y, "R5", longint'(out_y), last_y);
            end
        end
    end

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic send(input logic signed [SMP_W-1:0] v);
        @(negedge clk);
        in_vld = 1'b1;
        in_smp = v;
    endtask

    task automatic idle(input int n, input bit garbage);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            if (garbage) begin
                lf = lfsr_next(lf);
                in_smp = lf;
            end
        end
    endtask

    task automatic drain(input string req);
        idle(6, 1'b0);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0, "R1", longint'(out_vld), 0);
        check(longint'(out_y) == 0, "R1", longint'(out_y), 0);
    endtask

    task automatic t_impulse();
        cur_tag = "R7";
        send(16'sd1);
        idle(NTAPS + 1, 1'b0);
        drain("R7");
    endtask

    task automatic t_min_neg();
        cur_tag = "R6";
        send(-16'sd32768);
        idle(NTAPS, 1'b0);
        send(16'sd32767);
        send(-16'sd32768);
        idle(NTAPS, 1'b0);
        drain("R6");
    endtask

    task automatic t_gaps();
        cur_tag = "R4";
        for (int i = 0; i < 24; i++) begin
            lf = lfsr_next(lf);
            send(lf);
            idle(i % 4, 1'b1);
        end
        drain("R4");
    endtask

    task automatic t_stream();
        cur_tag = "R2";
        for (int i = 0; i < 300; i++) begin
            lf = lfsr_next(lf);
            send(lf);
        end
        for (int i = 0; i < 20; i++) begin
            send((i % 2 == 0) ? 16'sh7FFF : 16'sh8000);
        end
        drain("R2");
    endtask

    task automatic t_mid_reset();
        cur_tag = "R1";
        for (int i = 0; i < 5; i++) send(16'sd1000 + 16'(i));
        @(negedge clk);
        in_vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0, "R1", longint'(out_vld), 0);
        check(longint'(out_y) == 0, "R1", longint'(out_y), 0);
        @(negedge clk);
        rst_n = 1'b1;
        send(16'sd1);
        idle(2, 1'b0);
        drain("R1");
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_min_neg();
        t_gaps();
        t_stream();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule